// File: doc/BRIEF.md
# Sequential Shared Multiply/Divide Unit

This block computes a signed or unsigned integer product or quotient one bit per clock, over several cycles. A single double-width working register and a single adder serve all four operations. For a multiply, the multiplier sits in the low half of the register and drains out to the right while product bits fill in from the top. For a divide, the dividend sits in the low half, shifts left into the partial remainder, and is replaced by quotient bits. Signed operations run on magnitudes, and the signs are corrected in a final cycle.

Results go to two result registers. `hi` holds the upper product half or the remainder. `lo` holds the lower product half or the quotient. Both can be read at any time and change only when an operation completes. A request is a one-cycle `start` with the operands and the operation code. `busy` acts as the inverse of a ready signal: a request is taken only while it is low, and no request is queued. The unit has no overflow or zero-divisor detection. Those cases produce the fixed results stated below.

Top module: `seq_muldiv`

## Requirements
- R1: While reset is asserted and after it is released, `hi`, `lo`, `busy` and `done` are all zero until the first operation completes.
- R2: A rising clock edge with `start` high and `busy` low accepts a request, and `busy` is high from the next cycle. The `op_sel` encoding is: 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide. Bit 1 selects divide and bit 0 selects unsigned.
- R3: `busy` stays high for exactly W+1 cycles after the accepting edge. `done` is then high for exactly one cycle, the cycle in which `busy` is first low again.
- R4: Unsigned multiply gives the 2W-bit product a*b, with the upper W bits in `hi` and the lower W bits in `lo`.
- R5: Signed multiply gives the two's-complement 2W-bit product of the signed operands, split the same way as in R4.
- R6: Unsigned divide with a nonzero divisor puts a/b in `lo` and a mod b in `hi`.
- R7: Signed divide with a nonzero divisor truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative value divided by -1 wraps the quotient back to the most negative value, with remainder 0.
- R8: A zero divisor gives a fixed result, with `hi` equal to the dividend. Unsigned: `lo` is all ones. Signed: `lo` is all ones for a non-negative dividend and 1 for a negative dividend.
- R9: A `start` while `busy` is high has no effect. Operands and `op_sel` are sampled only on the accepting edge.
- R10: `hi` and `lo` hold their values in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only while `busy` is low |
| op_sel | input | 2 | Operation code (see R2) |
| opnd_a | input | W | Multiplicand or dividend |
| opnd_b | input | W | Multiplier or divisor |
| busy | output | 1 | Operation in progress; requests are refused |
| done | output | 1 | One-cycle completion pulse |
| hi | output | W | Upper product half or remainder |
| lo | output | W | Lower product half or quotient |

## Verification
Every result is due W+1 rising edges after the accepting edge, and `busy` must still be high one edge earlier. The bench drives requests on falling edges and samples on falling edges. Relative to the accepting edge, it checks `busy` one edge after, checks `done` low and `busy` high W edges after, and reads the result W+1 edges after. A 4-bit copy of the block is swept over every operand pair and every operation. A 32-bit copy is tested on directed corner cases. Hold and ignore behaviour is checked by changing the inputs after acceptance and by waiting idle cycles after completion before reading `hi` and `lo` again.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_MULU = 2'd1,
    OP_DIV  = 2'd2,
    OP_DIVU = 2'd3
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;
endpackage

// File: rtl/md_operand_prep.sv
// Converts operands to magnitudes and works out the result sign corrections.
module md_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_lo,
  output logic         neg_hi
);
  logic signed_op, sa, sb;

  always_comb begin
    signed_op = ~op[0];
    sa        = signed_op & a[W-1];
    sb        = signed_op & b[W-1];
    mag_a     = sa ? ({W{1'b0}} - a) : a;
    mag_b     = sb ? ({W{1'b0}} - b) : b;
    neg_lo    = sa ^ sb;
    // remainder follows the dividend; product halves follow the product
    neg_hi    = op[1] ? sa : (sa ^ sb);
  end
endmodule

// File: rtl/md_adder.sv
// The single adder shared by both operations; the top bit is the carry out.
module md_adder #(
  parameter int W = 32
) (
  input  logic [W:0]   x,
  input  logic [W:0]   y,
  input  logic         cin,
  output logic [W+1:0] s
);
  assign s = {1'b0, x} + {1'b0, y} + {{(W+1){1'b0}}, cin};
endmodule

// File: rtl/md_step_unit.sv
// One iteration of shift-and-add multiply or compare-subtract division.
module md_step_unit #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   opnd,
  input  logic           is_div,
  output logic [2*W-1:0] acc_nxt
);
  logic [W:0]   add_x, add_y;
  logic         add_cin;
  logic [W+1:0] add_s;

  always_comb begin
    if (is_div) begin
      add_x   = acc[2*W-1:W-1];
      add_y   = ~{1'b0, opnd};
      add_cin = 1'b1;
    end else begin
      add_x   = {1'b0, acc[2*W-1:W]};
      add_y   = {1'b0, opnd};
      add_cin = 1'b0;
    end
  end

  md_adder #(.W(W)) u_add (
    .x   (add_x),
    .y   (add_y),
    .cin (add_cin),
    .s   (add_s)
  );

  always_comb begin
    if (is_div) begin
      // carry out set means no borrow: keep the difference, quotient bit 1
      if (add_s[W+1]) acc_nxt = {add_s[W-1:0], acc[W-2:0], 1'b1};
      else            acc_nxt = {acc[2*W-2:0], 1'b0};
    end else begin
      if (acc[0]) acc_nxt = {add_s[W:0], acc[W-1:1]};
      else        acc_nxt = {1'b0, acc[2*W-1:1]};
    end
  end
endmodule

// File: rtl/md_sign_fix.sv
// Applies the sign corrections to the magnitude result.
module md_sign_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc,
  input  logic           is_div,
  input  logic           neg_lo,
  input  logic           neg_hi,
  output logic [W-1:0]   hi,
  output logic [W-1:0]   lo
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = neg_lo ? ({(2*W){1'b0}} - acc) : acc;
    if (is_div) begin
      lo = neg_lo ? ({W{1'b0}} - acc[W-1:0])   : acc[W-1:0];
      hi = neg_hi ? ({W{1'b0}} - acc[2*W-1:W]) : acc[2*W-1:W];
    end else begin
      lo = prod[W-1:0];
      hi = prod[2*W-1:W];
    end
  end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  md_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [2*W-1:0] acc_q, acc_nxt;
  logic [W-1:0]   opnd_q;
  logic           is_div_q, neg_lo_q, neg_hi_q;
  logic [W-1:0]   hi_q, lo_q, hi_fix, lo_fix;
  logic           done_q;
  logic [W-1:0]   mag_a, mag_b;
  logic           neg_lo_c, neg_hi_c;

  md_operand_prep #(.W(W)) u_prep (
    .a      (opnd_a),
    .b      (opnd_b),
    .op     (op_sel),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .neg_lo (neg_lo_c),
    .neg_hi (neg_hi_c)
  );

  md_step_unit #(.W(W)) u_step (
    .acc     (acc_q),
    .opnd    (opnd_q),
    .is_div  (is_div_q),
    .acc_nxt (acc_nxt)
  );

  md_sign_fix #(.W(W)) u_fix (
    .acc    (acc_q),
    .is_div (is_div_q),
    .neg_lo (neg_lo_q),
    .neg_hi (neg_hi_q),
    .hi     (hi_fix),
    .lo     (lo_fix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      acc_q    <= '0;
      opnd_q   <= '0;
      is_div_q <= 1'b0;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            acc_q    <= {{W{1'b0}}, (op_sel[1] ? mag_a : mag_b)};
            opnd_q   <= op_sel[1] ? mag_b : mag_a;
            is_div_q <= op_sel[1];
            neg_lo_q <= neg_lo_c;
            neg_hi_q <= neg_hi_c;
            cnt_q    <= '0;
            state_q  <= ST_STEP;
          end
        end
        ST_STEP: begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) state_q <= ST_FIN;
        end
        ST_FIN: begin
          hi_q    <= hi_fix;
          lo_q    <= lo_fix;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign hi   = hi_q;
  assign lo   = lo_q;
endmodule

// File: rtl/seq_muldiv_chk.sv
module seq_muldiv_chk
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int BW = $clog2(W + 3);

  logic [BW-1:0] busy_cnt;
  logic [1:0]    op_l;
  logic [W-1:0]  a_l, b_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      op_l     <= '0;
      a_l      <= '0;
      b_l      <= '0;
    end else begin
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
      if (start && !busy) begin
        op_l <= op_sel;
        a_l  <= opnd_a;
        b_l  <= opnd_b;
      end
    end
  end

  p_busy_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == BW'(W + 1)));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_zero_divisor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l == OP_DIVU && b_l == '0) |-> (lo == {W{1'b1}} && hi == a_l));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo)));
endmodule

bind seq_muldiv seq_muldiv_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .busy   (busy),
  .done   (done),
  .hi     (hi),
  .lo     (lo)
);

// File: tb/seq_muldiv_test.sv
`timescale 1ns/1ps
module seq_muldiv_test;
  localparam int WS = 4;
  localparam int WL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          s_start = 1'b0;
  logic [1:0]    s_op = '0;
  logic [WS-1:0] s_a = '0, s_b = '0;
  logic          s_busy, s_done;
  logic [WS-1:0] s_hi, s_lo;

  logic          l_start = 1'b0;
  logic [1:0]    l_op = '0;
  logic [WL-1:0] l_a = '0, l_b = '0;
  logic          l_busy, l_done;
  logic [WL-1:0] l_hi, l_lo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  seq_muldiv #(.W(WS)) uut (
    .clk(clk), .rst_n(rst_n), .start(s_start), .op_sel(s_op),
    .opnd_a(s_a), .opnd_b(s_b), .busy(s_busy), .done(s_done),
    .hi(s_hi), .lo(s_lo));

  seq_muldiv #(.W(WL)) uut32 (
    .clk(clk), .rst_n(rst_n), .start(l_start), .op_sel(l_op),
    .opnd_a(l_a), .opnd_b(l_b), .busy(l_busy), .done(l_done),
    .hi(l_hi), .lo(l_lo));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Arithmetic reference from the requirements (R4..R8).
  task automatic model(input longint unsigned a, input longint unsigned b,
                       input int op, input int w,
                       output longint unsigned ehi, output longint unsigned elo);
    longint unsigned mask;
    longint sa, sb, q, r;
    longint unsigned full;
    mask = (64'd1 << w) - 64'd1;
    sa = (((a >> (w - 1)) & 64'd1) != 0) ? longint'(a) - (longint'(1) << w) : longint'(a);
    sb = (((b >> (w - 1)) & 64'd1) != 0) ? longint'(b) - (longint'(1) << w) : longint'(b);
    full = 0;
    ehi = 0;
    elo = 0;
    case (op)
      0, 1: begin
        full = (op == 0) ? longint'(sa * sb) : a * b;
        elo  = full & mask;
        ehi  = (full >> w) & mask;
      end
      2: begin
        if (b == 0) begin
          elo = (sa < 0) ? 64'd1 : mask;
          ehi = a;
        end else begin
          q = sa / sb;
          r = sa % sb;
          elo = longint'(q) & mask;
          ehi = longint'(r) & mask;
        end
      end
      default: begin
        if (b == 0) begin
          elo = mask;
          ehi = a;
        end else begin
          elo = a / b;
          ehi = a % b;
        end
      end
    endcase
  endtask

  function automatic string req_of(input int op, input longint unsigned b);
    if (op >= 2 && b == 0) return "R8";
    case (op)
      0: return "R5";
      1: return "R4";
      2: return "R7";
      default: return "R6";
    endcase
  endfunction

  // Called just after a falling edge; returns just after the completion falling edge.
  task automatic run_small(input int a, input int b, input int op, input bit poke);
    longint unsigned ehi, elo;
    model(longint'(a), longint'(b), op, WS, ehi, elo);
    s_a = WS'(a); s_b = WS'(b); s_op = 2'(op); s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    s_a = ~s_a; s_b = ~s_b; s_op = s_op ^ 2'd2;  // R9: post-accept changes ignored
    chk(s_busy == 1'b1, "R2", "busy after accept", s_busy, 1);
    for (int i = 0; i < WS; i++) begin
      @(negedge clk);
      s_start = poke && (i == 0);  // R9: request while busy
    end
    chk(s_busy && !s_done, "R3", "busy one edge before done", {s_busy, s_done}, 2'b10);
    @(negedge clk);
    chk(s_done && !s_busy, "R3", "done pulse", {s_busy, s_done}, 2'b01);
    chk(s_hi == WS'(ehi) && s_lo == WS'(elo), poke ? "R9" : req_of(op, longint'(b)),
        $sformatf("op%0d a=%0d b=%0d", op, a, b), {s_hi, s_lo}, (ehi << WS) | elo);
  endtask

  task automatic run_wide(input longint unsigned a, input longint unsigned b, input int op);
    longint unsigned ehi, elo;
    model(a, b, op, WL, ehi, elo);
    l_a = WL'(a); l_b = WL'(b); l_op = 2'(op); l_start = 1'b1;
    @(negedge clk);
    l_start = 1'b0;
    l_a = ~l_a; l_b = ~l_b;
    chk(l_busy == 1'b1, "R2", "wide busy after accept", l_busy, 1);
    repeat (WL) @(negedge clk);
    chk(l_busy && !l_done, "R3", "wide busy before done", {l_busy, l_done}, 2'b10);
    @(negedge clk);
    chk(l_done && !l_busy, "R3", "wide done pulse", {l_busy, l_done}, 2'b01);
    chk(l_hi == WL'(ehi), req_of(op, b), $sformatf("wide hi op%0d", op), l_hi, ehi);
    chk(l_lo == WL'(elo), req_of(op, b), $sformatf("wide lo op%0d", op), l_lo, elo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(s_hi == 0 && s_lo == 0 && !s_busy && !s_done, "R1", "state in reset",
        {s_hi, s_lo, s_busy, s_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(l_hi == 0 && l_lo == 0 && !l_busy && !l_done, "R1", "state after release",
        {l_busy, l_done}, 0);

    // exhaustive sweep on the narrow copy
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < (1 << WS); a++)
        for (int b = 0; b < (1 << WS); b++)
          run_small(a, b, op, 1'b0);

    // R9: start while busy, with different operands on the bus
    run_small(7, 3, 3, 1'b1);
    run_small(9, 13, 0, 1'b1);

    // R10: results hold while idle and inputs wander
    run_small(6, 5, 1, 1'b0);
    s_a = 4'hF; s_b = 4'h1; s_op = 2'd3;
    repeat (5) @(negedge clk);
    chk(s_hi == 4'd1 && s_lo == 4'hE && !s_busy, "R10", "hold while idle", {s_hi, s_lo}, 8'h1E);

    // directed wide cases
    run_wide(64'h7fffffff, 64'h7fffffff, 1);
    run_wide(64'hffffffff, 64'hffffffff, 1);
    run_wide(64'hffffffff, 64'hffffffff, 0);
    run_wide(64'h80000000, 64'hffffffff, 0);
    run_wide(64'h80000000, 64'h80000000, 0);
    run_wide(64'hffffffff, 64'd7, 3);
    run_wide(64'hffffff9c, 64'd7, 2);
    run_wide(64'd100, 64'hfffffff9, 2);
    run_wide(64'h80000000, 64'hffffffff, 2);
    run_wide(64'h12345678, 64'd0, 3);
    run_wide(64'hfffffffb, 64'd0, 2);
    run_wide(64'd5, 64'd0, 2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule